// File: doc/BRIEF.md
# Block Traceback Survivor Unit for a 64-State Viterbi Decoder

This unit is the back end of a Viterbi decoder. Every accepted trellis step delivers one survivor decision vector, one bit per state, from the add-compare-select stage. The vectors go into an on-chip RAM that is split into four blocks of `BLK_LEN` steps each. The blocks are used in rotation. While the newest block is being filled, two tracebacks run side by side at one step per accepted sample.

The first traceback walks backwards through the block written just before. It starts from state 0 and is used only to settle on a survivor state. The second traceback starts from the state that the first one settled on in the previous block period. It walks backwards through an older block and produces that block's bits latest-first. A pair of bit banks turns the order around, so the decoded bits leave in time order, one per accepted input sample.

Bits are not required to match a per-bit register traceback. `BLK_LEN` should be set near ten constraint lengths (72 for a constraint length of 7).

Top module: `ram_traceback_decoder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `out_bit` are 0 after that edge.
- R2: No decoded bit is produced before the first 4·`BLK_LEN` decision vectors have been accepted. The first `out_valid` is registered at the edge that accepts sample 4·`BLK_LEN` (counting from 0).
- R3: Once output has begun, each accepted sample gives exactly one `out_valid` pulse, in the cycle right after that sample's edge. `out_valid` is never high after an edge where `in_valid` was low.
- R4: When every state's decision equals the true path's predecessor MSB, the decoded stream is the encoder input stream, delayed by 4·`BLK_LEN` accepted samples.
- R5: The start state for decoding block b comes from a traceback that begins at state 0 at the last step of block b+1 and walks back through all `BLK_LEN` vectors of block b+1.
- R6: State convention. The state after input bit u from state s is {s[W-2:0], u}, and the decoded bit of a step is bit 0 of that step's state. Bit k of a decision vector names the predecessor of state k as {decision bit, k[W-1:1]}.
- R7: A cycle with `in_valid` low leaves the write position, both traceback states and the bit banks unchanged. The decoded stream is identical to that of the same samples sent with no gaps.
- R8: Within each block the bits leave in ascending time order, even though they are found in descending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A decision vector is presented this cycle |
| in_dec | input | N_STATES | Survivor decision bit per state |
| out_valid | output | 1 | `out_bit` holds a decoded bit |
| out_bit | output | 1 | Decoded bit, in time order |

## Verification
The bench goes after four corner cases.

- **Output start point.** A unit that starts output one block early or late moves the first `out_valid` away from accepted sample 4·`BLK_LEN`.
- **Block order.** A noiseless stream made of all-zero, all-one and random blocks shows a reversal fault as mirrored bits inside each block. It shows a wrong block rotation as whole blocks out of place.
- **Seeding of the start state.** Random decision vectors do not always converge, so the result depends on the settling traceback starting from state 0 over the right block. A wrong seed or block gives bits that differ from the bench model.
- **Stalls.** Random input gaps catch a unit that advances during a stall: it would either emit during the gap or drift off the model.

// File: rtl/rtb_pkg.sv
// Package: shared constants and types for the block traceback unit.
// Assumes exactly four RAM blocks used in rotation.
package rtb_pkg;
    localparam int N_BLKS      = 4;
    localparam int BLK_IDX_W   = 2;
    // Number of completed blocks needed before decoding / output start
    localparam int FILL_DECODE = 3;
    localparam int FILL_OUTPUT = 4;

    typedef logic [BLK_IDX_W-1:0] blk_idx_t;
endpackage

// File: rtl/survivor_ram.sv
// Survivor memory: one write port and two registered read ports.
// Assumes the three addresses never collide (different blocks in use).
// All ports advance only when en is high, so read data holds through stalls.
module survivor_ram #(
    parameter int WORD_W = 64,
    parameter int DEPTH  = 288,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [WORD_W-1:0] rd_data_a,
    output logic [WORD_W-1:0] rd_data_b
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Store the new vector and fetch both traceback words
    always_ff @(posedge clk) begin
        if (en) begin
            mem[wr_addr] <= wr_data;
            rd_data_a    <= mem[rd_addr_a];
            rd_data_b    <= mem[rd_addr_b];
        end
    end
endmodule

// File: rtl/blk_sequencer.sv
// Block sequencer: keeps the step position inside the block being written
// and the block rotation. It produces the write address and the two
// traceback read addresses. The settling read walks the block written just
// before. The decode read walks the block three behind the one being written.
// Assumes en marks one accepted sample.
module blk_sequencer
    import rtb_pkg::*;
#(
    parameter int BLK_LEN = 72,
    parameter int ADDR_W  = 9,
    parameter int CNT_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic [CNT_W-1:0]  step,
    output blk_idx_t          wr_blk,
    output logic              first_step,
    output logic              dec_active,
    output logic              out_active,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] conv_addr,
    output logic [ADDR_W-1:0] dec_addr
);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(BLK_LEN - 1);

    logic [2:0]        blks_done;
    blk_idx_t          conv_blk;
    blk_idx_t          dec_blk;
    logic [ADDR_W-1:0] rev_off;

    function automatic logic [ADDR_W-1:0] blk_base(input blk_idx_t b);
        return ADDR_W'(b) * ADDR_W'(BLK_LEN);
    endfunction

    // Advance step position, block rotation and saturating fill count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step      <= '0;
            wr_blk    <= '0;
            blks_done <= '0;
        end else if (en) begin
            if (step == LAST_STEP) begin
                step   <= '0;
                wr_blk <= wr_blk + blk_idx_t'(1);
                if (blks_done != 3'(FILL_OUTPUT))
                    blks_done <= blks_done + 3'd1;
            end else begin
                step <= step + CNT_W'(1);
            end
        end
    end

    // Derive block roles and addresses from the current position
    always_comb begin
        conv_blk   = wr_blk - blk_idx_t'(1);
        dec_blk    = wr_blk - blk_idx_t'(3);
        rev_off    = ADDR_W'(BLK_LEN - 1) - ADDR_W'(step);
        wr_addr    = blk_base(wr_blk) + ADDR_W'(step);
        conv_addr  = blk_base(conv_blk) + rev_off;
        dec_addr   = blk_base(dec_blk) + rev_off;
        first_step = (step == '0);
        dec_active = (blks_done >= 3'(FILL_DECODE));
        out_active = (blks_done >= 3'(FILL_OUTPUT));
    end

    // R2: the position inside a block never leaves its range
    p_step_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step <= LAST_STEP);

    // R3: the last step of a block is followed by step 0 of the next block
    p_block_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step == LAST_STEP) |=> (step == '0 && wr_blk == $past(wr_blk) + blk_idx_t'(1)));

    // R7: a stalled cycle leaves the position untouched
    p_stall_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(step) && $stable(wr_blk)));
endmodule

// File: rtl/traceback_engine.sv
// Traceback engine: two survivor walks, one step each per accepted sample.
// The settling walk restarts from state 0 at each block start. At that point
// its final predecessor seeds the decode walk, which then yields one bit per
// step (bit 0 of the state), latest step first. Assumes survivor words arrive
// one accepted sample after their addresses were issued.
module traceback_engine #(
    parameter int N_STATES = 64,
    parameter int STATE_W  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                first_step,
    input  logic [N_STATES-1:0] surv_conv,
    input  logic [N_STATES-1:0] surv_dec,
    output logic                dec_bit
);
    logic [STATE_W-1:0] conv_st;
    logic [STATE_W-1:0] dec_st;
    logic [STATE_W-1:0] conv_next;
    logic [STATE_W-1:0] dec_next;

    // Predecessor lookup for both walks; block start hands over the seed
    always_comb begin
        conv_next = {surv_conv[conv_st], conv_st[STATE_W-1:1]};
        if (first_step)
            dec_next = conv_next;
        else
            dec_next = {surv_dec[dec_st], dec_st[STATE_W-1:1]};
        dec_bit = dec_next[0];
    end

    // Register the walk states on accepted samples only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_st <= '0;
            dec_st  <= '0;
        end else if (en) begin
            conv_st <= first_step ? '0 : conv_next;
            dec_st  <= dec_next;
        end
    end

    // R5: the settling walk begins each block from state 0
    p_conv_from_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && first_step) |=> (conv_st == '0));

    // R6: inside a block the decode state shifts right by one per step
    p_shift_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !first_step) |=> (dec_st[STATE_W-2:0] == $past(dec_st[STATE_W-1:1])));

    // R7: stalls freeze both walks
    p_stall_walks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(conv_st) && $stable(dec_st)));
endmodule

// File: rtl/bit_reverser.sv
// Bit reverser: two banks of BLK_LEN bits, filled and drained in alternation.
// The bank selected by the write block parity is filled at index
// BLK_LEN-1-step, latest bit first. The other bank is drained at index step,
// so each block leaves in time order. Assumes a bank is completely written
// one period before it is drained.
module bit_reverser #(
    parameter int BLK_LEN = 72,
    parameter int CNT_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr_bank,
    input  logic [CNT_W-1:0] step,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic             rd_en,
    output logic             out_bit,
    output logic             out_valid
);
    logic [BLK_LEN-1:0] banks [2];
    logic [1:0]         filled;
    logic               rd_sel_q;
    logic [CNT_W-1:0]   wr_idx;

    always_comb wr_idx = CNT_W'(BLK_LEN - 1) - step;

    // One storage bank per generate pass, written in reverse order
    for (genvar b = 0; b < 2; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                banks[b]  <= '0;
                filled[b] <= 1'b0;
            end else if (en && wr_en && (wr_bank == b[0])) begin
                banks[b][wr_idx] <= wr_bit;
                if (wr_idx == '0)
                    filled[b] <= 1'b1;
            end
        end
    end

    // Drain the opposite bank in ascending order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_bit   <= 1'b0;
            out_valid <= 1'b0;
            rd_sel_q  <= 1'b0;
        end else begin
            out_valid <= en && rd_en;
            if (en && rd_en) begin
                out_bit  <= banks[~wr_bank][step];
                rd_sel_q <= ~wr_bank;
            end
        end
    end

    // R3: output only ever follows an accepted sample
    p_out_after_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(en));

    // R8: a bank is drained only after its earliest bit has been written
    p_drain_filled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> filled[rd_sel_q]);
endmodule

// File: rtl/ram_traceback_decoder.sv
// Top: survivor RAM with block traceback and bit reversal.
// Takes one decision vector per accepted sample and emits one decoded bit per
// accepted sample once four blocks have been written. Assumes N_STATES is a
// power of two with at least two states.
module ram_traceback_decoder
    import rtb_pkg::*;
#(
    parameter int N_STATES = 64,
    parameter int BLK_LEN  = 72
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [N_STATES-1:0] in_dec,
    output logic                out_valid,
    output logic                out_bit
);
    localparam int STATE_W = $clog2(N_STATES);
    localparam int DEPTH   = N_BLKS * BLK_LEN;
    localparam int ADDR_W  = $clog2(DEPTH);
    localparam int CNT_W   = $clog2(BLK_LEN);

    logic [CNT_W-1:0]    step;
    blk_idx_t            wr_blk;
    logic                first_step;
    logic                dec_active;
    logic                out_active;
    logic [ADDR_W-1:0]   wr_addr;
    logic [ADDR_W-1:0]   conv_addr;
    logic [ADDR_W-1:0]   dec_addr;
    logic [N_STATES-1:0] surv_conv;
    logic [N_STATES-1:0] surv_dec;
    logic                dec_bit;

    blk_sequencer #(
        .BLK_LEN (BLK_LEN),
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (in_valid),
        .step       (step),
        .wr_blk     (wr_blk),
        .first_step (first_step),
        .dec_active (dec_active),
        .out_active (out_active),
        .wr_addr    (wr_addr),
        .conv_addr  (conv_addr),
        .dec_addr   (dec_addr)
    );

    survivor_ram #(
        .WORD_W (N_STATES),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .clk       (clk),
        .en        (in_valid),
        .wr_addr   (wr_addr),
        .wr_data   (in_dec),
        .rd_addr_a (conv_addr),
        .rd_addr_b (dec_addr),
        .rd_data_a (surv_conv),
        .rd_data_b (surv_dec)
    );

    traceback_engine #(
        .N_STATES (N_STATES),
        .STATE_W  (STATE_W)
    ) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (in_valid),
        .first_step (first_step),
        .surv_conv  (surv_conv),
        .surv_dec   (surv_dec),
        .dec_bit    (dec_bit)
    );

    bit_reverser #(
        .BLK_LEN (BLK_LEN),
        .CNT_W   (CNT_W)
    ) u_rev (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (in_valid),
        .wr_bank   (wr_blk[0]),
        .step      (step),
        .wr_en     (dec_active),
        .wr_bit    (dec_bit),
        .rd_en     (out_active),
        .out_bit   (out_bit),
        .out_valid (out_valid)
    );

    // R1: reset leaves the output idle
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_bit));

    // R2: output needs the decode path to have been running
    p_no_early_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(dec_active));
endmodule

// File: tb/tb_ram_traceback_decoder.sv
// Bench: a noiseless stream with continuous input, then random decision
// vectors with random input gaps. Outputs are checked against bench models.
module tb_ram_traceback_decoder;
    localparam int NS = 64;
    localparam int SW = 6;
    localparam int M  = 72;
    localparam int NB = 10;
    localparam int NSAMP = NB * M;
    localparam int NOUT  = (NB - 4) * M;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [NS-1:0] in_dec = '0;
    logic          out_valid;
    logic          out_bit;

    int n_checks = 0;
    int n_fail   = 0;
    int n_out    = 0;
    int accepted = 0;
    bit finished = 1'b0;

    logic [NS-1:0] dv   [NSAMP];
    logic          expb [NSAMP];
    logic          got  [NSAMP];

    ram_traceback_decoder #(.N_STATES(NS), .BLK_LEN(M)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dec(in_dec),
        .out_valid(out_valid), .out_bit(out_bit)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Output monitor: samples 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n && out_valid) begin
            chk(in_valid, "R3", "out_valid without accepted sample", 0, 1);
            if (n_out == 0)
                chk(accepted == 4 * M, "R2", "samples before first output", accepted, 4 * M);
            if (n_out < NSAMP) got[n_out] = out_bit;
            n_out++;
        end
        if (rst_n && in_valid) accepted++;
    end

    task automatic drive(input logic v, input logic [NS-1:0] d);
        @(negedge clk);
        in_valid = v;
        in_dec   = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_bit, "R1", "outputs during reset",
            int'({out_valid, out_bit}), 0);
        n_out = 0;
        accepted = 0;
        rst_n = 1'b1;
    endtask

    // Bench model of the block traceback (R5, R6)
    task automatic model_blocks();
        for (int b = 0; b < NB - 4; b++) begin
            logic [SW-1:0] s = '0;
            for (int t = M - 1; t >= 0; t--)
                s = {dv[(b + 1) * M + t][s], s[SW-1:1]};
            for (int t = M - 1; t >= 0; t--) begin
                expb[b * M + t] = s[0];
                s = {dv[b * M + t][s], s[SW-1:1]};
            end
        end
    endtask

    task automatic send_all(input int gap_pct);
        for (int i = 0; i < NSAMP; i++) begin
            while (($urandom % 100) < gap_pct)
                drive(1'b0, {$urandom, $urandom});
            drive(1'b1, dv[i]);
        end
        drive(1'b0, '0);
        repeat (6) drive(1'b0, '0);
    endtask

    task automatic compare(input string req);
        int bad = 0;
        chk(n_out == NOUT, "R3", "output count", n_out, NOUT);
        for (int k = 0; k < NOUT; k++) begin
            if (got[k] !== expb[k]) begin
                bad++;
                if (bad <= 8) chk(1'b0, req, $sformatf("bit %0d", k), int'(got[k]), int'(expb[k]));
            end
        end
        chk(bad == 0, req, "mismatching bits", bad, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        // Phase A: noiseless, continuous (R4, R8); blocks of zeros, ones, random
        do_reset();
        begin
            logic [SW-1:0] s = '0;
            for (int i = 0; i < NSAMP; i++) begin
                logic u;
                logic [SW-1:0] prev;
                if (i < M) u = 1'b0;
                else if (i < 2 * M) u = 1'b1;
                else u = 1'($urandom);
                prev = s;
                s = {s[SW-2:0], u};
                dv[i] = {NS{prev[SW-1]}};
                expb[i] = u;
            end
        end
        send_all(0);
        compare("R4 R8");

        // Phase B: random decisions with stalls (R5, R6, R7)
        do_reset();
        for (int i = 0; i < NSAMP; i++) dv[i] = {$urandom, $urandom};
        model_blocks();
        send_all(30);
        compare("R5 R6 R7");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #(20 * 150000);
        if (!finished) begin
            chk(1'b0, "WDOG", "run did not finish", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule